// File: doc/BRIEF.md
# Keyboard and Mouse Wake Detector

This block watches the byte stream delivered by a keyboard interface and the packet events delivered by a mouse interface. From them it raises power-management requests. Three programmable key sequences, called Power, Sleep and Resume, are matched at the same time against the same keyboard bytes. Each sequence is 1 to 8 bytes long. When a sequence completes, the block emits a one-cycle pulse for it and latches a status bit.

Two more wake sources sit beside the sequence matchers. The first is an any-key mode, in which every received byte latches a status bit. The second is mouse wake, which fires on pointer movement, on a button press, or on either, as selected. A single wake request output combines every latched status bit whose source is enabled. The status bits are cleared by writing ones to a clear register.

Configuration goes through a simple byte-wide write port. Address map:

| Addresses | Contents |
|---|---|
| `s*8 + i` (0..23) | Byte `i` of sequence `s`. Sequence 0 is Power, 1 is Sleep, 2 is Resume. |
| `24 + s` | Control register of sequence `s`. Bits [2:0] hold the length minus one. Bit 7 enables the sequence. |
| 27 | Mode register. Bit 0 enables any-key wake, bit 1 enables movement wake, bit 2 enables click wake. |
| 28 | Write-one-to-clear register for the status bits. |

Top module: `kbd_wake_top`

## Requirements
- R1: A sequence whose control register holds length-minus-one value L (bits [2:0]) and enable bit 7 set produces a pulse on `seqPulse[s]` in the cycle after the clock edge that accepts byte L+1 of a matching run. The pulse lasts one cycle per match. This holds for every length from 1 to 8.
- R2: The three matchers run independently on the same keyboard byte stream, so one byte may complete several sequences in the same cycle.
- R3: A byte that does not match the expected byte moves the matcher back to position 1 if it equals byte 0 of the sequence, and to position 0 otherwise.
- R4: A completed match latches `statusBits[s]` and returns the matcher to position 0, so overlapping bytes are not reused for the next match.
- R5: A sequence whose enable bit is 0 never pulses and never sets its status bit.
- R6: With mode bit 0 set, every accepted keyboard byte sets `statusBits[3]` one cycle later. With mode bit 0 clear, keyboard bytes do not touch that bit.
- R7: With mode bit 1 set, a mouse packet that has a nonzero X or Y delta sets `statusBits[4]`.
- R8: With mode bit 2 set, a mouse packet in which any button bit changes from 0 (in the previous packet) to 1 sets `statusBits[4]`. Buttons held at 1 do not set it.
- R9: Writing to address 28 clears every status bit whose corresponding data bit is 1. Bits 0..2 map to the sequences, bit 3 to any-key and bit 4 to mouse. A set event in the same cycle wins over the clear. Status bits otherwise stay set.
- R10: After reset all outputs are 0. `wakeReq` is the OR of the status bits masked by their source enables: sequence enables, mode bit 0, and mode bit 1 OR mode bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration write address |
| cfgWrData | input | 8 | Configuration write data |
| keyValid | input | 1 | Keyboard byte strobe |
| keyByte | input | 8 | Keyboard scan-code byte |
| mouseValid | input | 1 | Mouse packet strobe |
| mouseDx | input | 9 | Mouse X delta |
| mouseDy | input | 9 | Mouse Y delta |
| mouseBtn | input | 3 | Mouse button states |
| seqPulse | output | 3 | Per-sequence match pulse |
| statusBits | output | 5 | Latched wake status |
| wakeReq | output | 1 | Combined wake request |

## Verification
A matcher position that goes wrong stays hidden until the end of a sequence. It shows up only as a missing or extra `seqPulse` bit one cycle after the final byte, so the tests end each stream exactly on the byte that should, or should not, complete a match. A stale previous-button register shows on `statusBits[4]` one cycle after the next mouse packet. Faults in clearing or masking show on `statusBits` and `wakeReq` one cycle after the configuration write.

// File: rtl/kwake_pkg.sv
package kwake_pkg;
  localparam int unsigned KW_NSEQ = 3;

  typedef struct packed {
    logic [KW_NSEQ-1:0] seqHit;
    logic               anyHit;
    logic               mouseHit;
  } kwStrobe_t;
endpackage

// File: rtl/kwake_ctrl.sv
module kwake_ctrl
  import kwake_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned DELTA_W = 9,
  parameter int unsigned BTN_W   = 3,
  localparam int unsigned PW     = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        byteValid,
  input  logic [KW_NSEQ-1:0]          eqPos,
  input  logic [KW_NSEQ-1:0]          eqFirst,
  input  logic [KW_NSEQ-1:0][PW-1:0]  seqLenM1,
  input  logic [KW_NSEQ-1:0]          seqEn,
  input  logic                        anyEn,
  input  logic                        moveEn,
  input  logic                        clickEn,
  input  logic                        mouseValid,
  input  logic [DELTA_W-1:0]          mouseDx,
  input  logic [DELTA_W-1:0]          mouseDy,
  input  logic [BTN_W-1:0]            mouseBtn,
  output logic [KW_NSEQ-1:0][PW-1:0]  posIdx,
  output kwStrobe_t                   strobe
);
  logic [KW_NSEQ-1:0] seqHitV;
  logic [BTN_W-1:0]   prevBtn;
  logic               moved;
  logic               clicked;

  for (genvar s = 0; s < KW_NSEQ; s++) begin : g_seq
    logic [PW-1:0] posQ;
    logic [PW-1:0] posD;
    logic          hit;

    always_comb begin
      posD = posQ;
      hit  = 1'b0;
      if (!seqEn[s]) begin
        posD = '0;
      end else if (byteValid) begin
        if (eqPos[s]) begin
          if (posQ >= seqLenM1[s]) begin
            hit  = 1'b1;
            posD = '0;
          end else begin
            posD = posQ + PW'(1);
          end
        end else if (eqFirst[s]) begin
          posD = PW'(1);
        end else begin
          posD = '0;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) posQ <= '0;
      else       posQ <= posD;
    end

    assign posIdx[s]  = posQ;
    assign seqHitV[s] = hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           prevBtn <= '0;
    else if (mouseValid) prevBtn <= mouseBtn;
  end

  assign moved   = (|mouseDx) || (|mouseDy);
  assign clicked = |(mouseBtn & ~prevBtn);

  always_comb begin
    strobe.seqHit   = seqHitV;
    strobe.anyHit   = byteValid && anyEn;
    strobe.mouseHit = mouseValid && ((moveEn && moved) || (clickEn && clicked));
  end

  // R8
  click_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mouseValid && $past(mouseValid) && (mouseBtn == $past(mouseBtn)) && clickEn && !moveEn)
      |-> !strobe.mouseHit);
endmodule

// File: rtl/kwake_dpath.sv
module kwake_dpath
  import kwake_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PW        = $clog2(DEPTH),
  localparam int unsigned CTRL_BASE = KW_NSEQ * DEPTH,
  localparam int unsigned MODE_ADDR = CTRL_BASE + KW_NSEQ,
  localparam int unsigned CLR_ADDR  = MODE_ADDR + 1,
  localparam int unsigned ADDR_W    = $clog2(CLR_ADDR + 1),
  localparam int unsigned STAT_W    = KW_NSEQ + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [ADDR_W-1:0]           cfgAddr,
  input  logic [BYTE_W-1:0]           cfgWrData,
  input  logic                        byteValid,
  input  logic [BYTE_W-1:0]           byteData,
  input  logic [KW_NSEQ-1:0][PW-1:0]  posIdx,
  input  kwStrobe_t                   strobe,
  output logic [KW_NSEQ-1:0]          eqPos,
  output logic [KW_NSEQ-1:0]          eqFirst,
  output logic [KW_NSEQ-1:0][PW-1:0]  seqLenM1,
  output logic [KW_NSEQ-1:0]          seqEn,
  output logic                        anyEn,
  output logic                        moveEn,
  output logic                        clickEn,
  output logic [KW_NSEQ-1:0]          seqPulse,
  output logic [STAT_W-1:0]           statusBits,
  output logic                        wakeReq
);
  logic [BYTE_W-1:0] seqMem [KW_NSEQ][DEPTH];
  logic [STAT_W-1:0] statusQ;
  logic [STAT_W-1:0] setMask;
  logic [STAT_W-1:0] clrMask;
  logic [STAT_W-1:0] enMask;
  logic              clrWrite;

  assign clrWrite = cfgWrEn && (cfgAddr == ADDR_W'(CLR_ADDR));
  assign clrMask  = clrWrite ? cfgWrData[STAT_W-1:0] : '0;
  assign setMask  = {strobe.mouseHit, strobe.anyHit, strobe.seqHit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < KW_NSEQ; s++) begin
        for (int i = 0; i < DEPTH; i++) seqMem[s][i] <= '0;
      end
      seqLenM1 <= '0;
      seqEn    <= '0;
      anyEn    <= 1'b0;
      moveEn   <= 1'b0;
      clickEn  <= 1'b0;
      statusQ  <= '0;
      seqPulse <= '0;
    end else begin
      if (cfgWrEn) begin
        for (int s = 0; s < KW_NSEQ; s++) begin
          for (int i = 0; i < DEPTH; i++) begin
            if (cfgAddr == ADDR_W'(s * DEPTH + i)) seqMem[s][i] <= cfgWrData;
          end
          if (cfgAddr == ADDR_W'(CTRL_BASE + s)) begin
            seqLenM1[s] <= cfgWrData[PW-1:0];
            seqEn[s]    <= cfgWrData[BYTE_W-1];
          end
        end
        if (cfgAddr == ADDR_W'(MODE_ADDR)) begin
          anyEn   <= cfgWrData[0];
          moveEn  <= cfgWrData[1];
          clickEn <= cfgWrData[2];
        end
      end
      statusQ  <= (statusQ & ~clrMask) | setMask;
      seqPulse <= strobe.seqHit;
    end
  end

  for (genvar s = 0; s < KW_NSEQ; s++) begin : g_cmp
    assign eqPos[s]   = (seqMem[s][posIdx[s]] == byteData);
    assign eqFirst[s] = (seqMem[s][0] == byteData);

    // R1
    hit_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
      seqPulse[s] |-> $past(byteValid));
    // R5
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      seqPulse[s] |-> $past(seqEn[s]));
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[b] && !(clrWrite && cfgWrData[b])) |=> statusQ[b]);
  end

  assign enMask     = {moveEn | clickEn, anyEn, seqEn};
  assign statusBits = statusQ;
  assign wakeReq    = |(statusQ & enMask);

  // R10
  wake_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (statusQ != '0));
  // R6
  any_key_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && anyEn) |=> statusQ[KW_NSEQ]);
endmodule

// File: rtl/kbd_wake_top.sv
module kbd_wake_top
  import kwake_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned DELTA_W = 9,
  parameter int unsigned BTN_W   = 3,
  localparam int unsigned PW     = $clog2(DEPTH),
  localparam int unsigned ADDR_W = $clog2(KW_NSEQ * DEPTH + KW_NSEQ + 2),
  localparam int unsigned STAT_W = KW_NSEQ + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [BYTE_W-1:0]  cfgWrData,
  input  logic               keyValid,
  input  logic [BYTE_W-1:0]  keyByte,
  input  logic               mouseValid,
  input  logic [DELTA_W-1:0] mouseDx,
  input  logic [DELTA_W-1:0] mouseDy,
  input  logic [BTN_W-1:0]   mouseBtn,
  output logic [KW_NSEQ-1:0] seqPulse,
  output logic [STAT_W-1:0]  statusBits,
  output logic               wakeReq
);
  logic [KW_NSEQ-1:0]         eqPos;
  logic [KW_NSEQ-1:0]         eqFirst;
  logic [KW_NSEQ-1:0][PW-1:0] seqLenM1;
  logic [KW_NSEQ-1:0][PW-1:0] posIdx;
  logic [KW_NSEQ-1:0]         seqEn;
  logic                       anyEn;
  logic                       moveEn;
  logic                       clickEn;
  kwStrobe_t                  strobe;

  kwake_ctrl #(.DEPTH(DEPTH), .DELTA_W(DELTA_W), .BTN_W(BTN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(keyValid),
    .eqPos(eqPos), .eqFirst(eqFirst), .seqLenM1(seqLenM1), .seqEn(seqEn),
    .anyEn(anyEn), .moveEn(moveEn), .clickEn(clickEn),
    .mouseValid(mouseValid), .mouseDx(mouseDx), .mouseDy(mouseDy),
    .mouseBtn(mouseBtn), .posIdx(posIdx), .strobe(strobe)
  );

  kwake_dpath #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .byteValid(keyValid), .byteData(keyByte),
    .posIdx(posIdx), .strobe(strobe), .eqPos(eqPos), .eqFirst(eqFirst),
    .seqLenM1(seqLenM1), .seqEn(seqEn), .anyEn(anyEn), .moveEn(moveEn),
    .clickEn(clickEn), .seqPulse(seqPulse), .statusBits(statusBits),
    .wakeReq(wakeReq)
  );
endmodule

// File: tb/kbd_wake_top_tb.sv
module kbd_wake_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       keyValid = 1'b0;
  logic [7:0] keyByte = '0;
  logic       mouseValid = 1'b0;
  logic [8:0] mouseDx = '0;
  logic [8:0] mouseDy = '0;
  logic [2:0] mouseBtn = '0;
  logic [2:0] seqPulse;
  logic [4:0] statusBits;
  logic       wakeReq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  kbd_wake_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .keyValid(keyValid), .keyByte(keyByte),
    .mouseValid(mouseValid), .mouseDx(mouseDx), .mouseDy(mouseDy),
    .mouseBtn(mouseBtn), .seqPulse(seqPulse), .statusBits(statusBits),
    .wakeReq(wakeReq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // drives one byte; on return the cycle after acceptance is visible
  task automatic sendKey(input logic [7:0] b);
    @(negedge clk);
    keyValid = 1'b1; keyByte = b;
    @(negedge clk);
    keyValid = 1'b0;
  endtask

  task automatic sendMouse(input logic [8:0] dx, input logic [8:0] dy, input logic [2:0] btn);
    @(negedge clk);
    mouseValid = 1'b1; mouseDx = dx; mouseDy = dy; mouseBtn = btn;
    @(negedge clk);
    mouseValid = 1'b0;
  endtask

  task automatic clearAll();
    cfgWrite(5'd28, 8'h1F);
  endtask

  task automatic t_reset();
    chk("R10 reset status", {3'b0, statusBits}, 8'h00);
    chk("R10 reset wake", {7'b0, wakeReq}, 8'h00);
    chk("R10 reset pulse", {5'b0, seqPulse}, 8'h00);
  endtask

  task automatic t_program();
    cfgWrite(5'd0, 8'h11); cfgWrite(5'd1, 8'h22); cfgWrite(5'd2, 8'h33);
    cfgWrite(5'd24, 8'h82);
    cfgWrite(5'd8, 8'h22); cfgWrite(5'd9, 8'h33);
    cfgWrite(5'd25, 8'h81);
    cfgWrite(5'd16, 8'h44);
    cfgWrite(5'd26, 8'h80);
  endtask

  task automatic t_simultaneous();
    sendKey(8'h11); chk("R2 no pulse byte1", {5'b0, seqPulse}, 8'h00);
    sendKey(8'h22); chk("R2 no pulse byte2", {5'b0, seqPulse}, 8'h00);
    sendKey(8'h33); chk("R2 two sequences end together", {5'b0, seqPulse}, 8'h03);
    chk("R4 status latched", {3'b0, statusBits}, 8'h03);
    chk("R10 wake set", {7'b0, wakeReq}, 8'h01);
    @(negedge clk); chk("R1 pulse one cycle", {5'b0, seqPulse}, 8'h00);
    sendKey(8'h44); chk("R1 length one", {5'b0, seqPulse}, 8'h04);
    clearAll();
    chk("R9 clear all", {3'b0, statusBits}, 8'h00);
    chk("R10 wake after clear", {7'b0, wakeReq}, 8'h00);
  endtask

  task automatic t_restart();
    sendKey(8'h11); sendKey(8'h11); sendKey(8'h22); sendKey(8'h33);
    chk("R3 restart at first byte", {5'b0, seqPulse}, 8'h03);
    sendKey(8'h11); sendKey(8'h22); sendKey(8'h55); sendKey(8'h33);
    chk("R3 mismatch resets", {5'b0, seqPulse}, 8'h00);
    clearAll();
  endtask

  task automatic t_rematch();
    cfgWrite(5'd9, 8'h22);
    sendKey(8'h22); chk("R4 rematch b1", {5'b0, seqPulse}, 8'h00);
    sendKey(8'h22); chk("R4 rematch b2", {5'b0, seqPulse}, 8'h02);
    sendKey(8'h22); chk("R4 no reuse b3", {5'b0, seqPulse}, 8'h00);
    sendKey(8'h22); chk("R4 rematch b4", {5'b0, seqPulse}, 8'h02);
    clearAll();
  endtask

  task automatic t_len8();
    int early = 0;
    for (int i = 0; i < 8; i++) cfgWrite(5'(16 + i), 8'(i + 1));
    cfgWrite(5'd26, 8'h87);
    for (int i = 0; i < 7; i++) begin
      sendKey(8'(i + 1));
      if (seqPulse[2]) early++;
    end
    chk("R1 no early pulse len8", 8'(early), 8'h00);
    sendKey(8'h08); chk("R1 len8 match", {5'b0, seqPulse}, 8'h04);
    clearAll();
  endtask

  task automatic t_disable();
    cfgWrite(5'd25, 8'h01);
    sendKey(8'h22); sendKey(8'h22);
    chk("R5 disabled no pulse", {5'b0, seqPulse}, 8'h00);
    chk("R5 disabled no status", {3'b0, statusBits}, 8'h00);
  endtask

  task automatic t_anykey();
    sendKey(8'h77);
    chk("R6 any-key off", {3'b0, statusBits}, 8'h00);
    cfgWrite(5'd27, 8'h01);
    sendKey(8'h77);
    chk("R6 any-key sets", {3'b0, statusBits}, 8'h08);
    chk("R10 wake any-key", {7'b0, wakeReq}, 8'h01);
    cfgWrite(5'd27, 8'h00);
    chk("R10 wake masked", {7'b0, wakeReq}, 8'h00);
    chk("R10 status kept when masked", {3'b0, statusBits}, 8'h08);
    cfgWrite(5'd27, 8'h01);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 5'd28; cfgWrData = 8'h1F;
    keyValid = 1'b1; keyByte = 8'h66;
    @(negedge clk);
    cfgWrEn = 1'b0; keyValid = 1'b0;
    chk("R9 set wins over clear", {3'b0, statusBits}, 8'h08);
    cfgWrite(5'd27, 8'h00);
    clearAll();
  endtask

  task automatic t_mouse();
    cfgWrite(5'd27, 8'h02);
    sendMouse(9'd0, 9'd0, 3'b000);
    chk("R7 zero delta", {3'b0, statusBits}, 8'h00);
    sendMouse(9'd5, 9'd0, 3'b000);
    chk("R7 x delta", {3'b0, statusBits}, 8'h10);
    clearAll();
    sendMouse(9'd0, 9'h1FF, 3'b000);
    chk("R7 y delta", {3'b0, statusBits}, 8'h10);
    clearAll();
    sendMouse(9'd0, 9'd0, 3'b001);
    chk("R8 click disabled", {3'b0, statusBits}, 8'h00);
    cfgWrite(5'd27, 8'h04);
    sendMouse(9'd0, 9'd0, 3'b001);
    chk("R8 held button", {3'b0, statusBits}, 8'h00);
    sendMouse(9'd0, 9'd0, 3'b000);
    chk("R8 release", {3'b0, statusBits}, 8'h00);
    sendMouse(9'd0, 9'd0, 3'b010);
    chk("R8 press", {3'b0, statusBits}, 8'h10);
    chk("R10 wake mouse", {7'b0, wakeReq}, 8'h01);
    clearAll();
    sendMouse(9'd3, 9'd0, 3'b010);
    chk("R8 move ignored click-only", {3'b0, statusBits}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_simultaneous();
    t_restart();
    t_rematch();
    t_len8();
    t_disable();
    t_anykey();
    t_mouse();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule